// File: doc/BRIEF.md
# Masked-Write GPIO Controller with Peripheral Pad Muxing

This block is a register-mapped general-purpose I/O controller for up to 32 pads behind a simple 32-bit word-addressed register bus. Each pad has a 2-bit mode field that decides whether the GPIO logic drives it. It also has a per-pad alternate-select bit that hands the pad's output enable and output value to a peripheral instead. Software changes individual output bits without a read-modify-write. It first loads a write-enable mask and then writes the output data word, and only the masked bits take the new value.

Pad levels pass through a two-flop synchronizer. The synchronized levels are readable as the input word and are also forwarded to the peripherals. A small bus state machine has two states: `BUS_IDLE` (ready, accepts a read or a write) and `BUS_RESP` (read data valid, not ready). A read accepted in `BUS_IDLE` moves to `BUS_RESP`. `BUS_RESP` always returns to `BUS_IDLE` after one cycle. A write is applied at the accepting edge, and the machine stays in `BUS_IDLE`.

Top module: `gpio_mux_ctrl`

## Requirements
- R1: After reset every register reads zero, `pad_oe` is all zero, `bus_ready` is 1 and `bus_rvalid` is 0.
- R2: A read accepted while `bus_ready` is 1 gives `bus_rvalid`=1 with the data on the next cycle, `bus_ready`=0 in that cycle, and `bus_ready`=1 again one cycle later.
- R3: Word 0 is read-only and returns the pad levels sampled two clock edges earlier, one bit per pin; a write to word 0 changes nothing.
- R4: A write to word 2 (output data) changes only the bits whose bit is 1 in word 1 (write mask); every other output bit keeps its value.
- R5: Words 1, 3, 4, 5 and 6 (mask, mode-low, mode-high, alternate-select, spare) read back the last value written, zero in unused upper bits.
- R6: Pin p below MODE_SPLIT (default 16) takes its mode from word 3 bits [2p+1:2p]; pin p at or above it uses word 4 bits [2(p-MODE_SPLIT)+1:2(p-MODE_SPLIT)].
- R7: With its alternate-select bit (word 5 bit p) at 0, pin p has `pad_oe[p]`=1 only for mode code 01, and codes 00, 10 and 11 leave the driver off. `pad_out[p]` equals output data bit p.
- R8: With alternate-select bit p at 1, `pad_oe[p]` equals `alt_oe[p]` and `pad_out[p]` equals `alt_out[p]`, whatever the mode field and data hold.
- R9: Word 7 reads zero and a write to it has no effect on any register.
- R10: `alt_in` presents the same synchronized pad levels as word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Controller can accept a request |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| alt_out | input | 32 | Peripheral output values |
| alt_oe | input | 32 | Peripheral output enables |
| alt_in | output | 32 | Synchronized pad levels for peripherals |

## Verification
The assertions assume that requests are only meaningful while `bus_ready` is high. They also assume that a pad change counts as seen only two edges after it is sampled. The synchronizer check only begins once two edges have passed since reset. The stimulus drives every request at the falling edge and holds it for exactly one rising edge while the controller is idle. After each change of `pad_in`, it waits three cycles before it reads word 0 or compares `alt_in`. Register addresses, data, pad levels and peripheral signals are drawn at random from a fixed seed. Directed cases cover the mode split boundary, the mask and the ignored words.

// File: rtl/gpio_mux_pkg.sv
package gpio_mux_pkg;
    localparam int BUS_DW = 32;

    // Word indices of the register map
    localparam logic [2:0] W_PIN_LVL  = 3'd0;
    localparam logic [2:0] W_WR_MASK  = 3'd1;
    localparam logic [2:0] W_OUT_DATA = 3'd2;
    localparam logic [2:0] W_MODE_LO  = 3'd3;
    localparam logic [2:0] W_MODE_HI  = 3'd4;
    localparam logic [2:0] W_ALT_SEL  = 3'd5;
    localparam logic [2:0] W_SPARE    = 3'd6;

    // Per-pin mode codes (only 01 drives the pad)
    localparam logic [1:0] PM_INPUT  = 2'b00;
    localparam logic [1:0] PM_OUTPUT = 2'b01;

    typedef enum logic [0:0] {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_t;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_bus_fsm.sv
module gpio_bus_fsm
    import gpio_mux_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [BUS_DW-1:0] rd_word,
    output logic              wr_fire,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [BUS_DW-1:0] bus_rdata
);
    bus_state_t state_q, state_d;
    logic [BUS_DW-1:0] rdata_q;
    logic rd_fire;

    assign rd_fire = bus_req && !bus_we && (state_q == BUS_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_fire) rdata_q <= rd_word;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (rd_fire) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_comb begin
        wr_fire    = 1'b0;
        bus_ready  = 1'b0;
        bus_rvalid = 1'b0;
        bus_rdata  = '0;
        unique case (state_q)
            BUS_IDLE: begin
                bus_ready = 1'b1;
                wr_fire   = bus_req && bus_we;
            end
            BUS_RESP: begin
                bus_rvalid = 1'b1;
                bus_rdata  = rdata_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_mux_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int MODE_SPLIT = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_fire,
    input  logic [2:0]                        addr,
    input  logic [BUS_DW-1:0]                 wdata,
    input  logic [NPINS-1:0]                  pin_lvl,
    output logic [BUS_DW-1:0]                 rd_word,
    output logic [NPINS-1:0]                  mask_q,
    output logic [NPINS-1:0]                  odata_q,
    output logic [2*MODE_SPLIT-1:0]           mode_lo_q,
    output logic [2*(NPINS-MODE_SPLIT)-1:0]   mode_hi_q,
    output logic [NPINS-1:0]                  alt_q
);
    localparam int LO_W = 2 * MODE_SPLIT;
    localparam int HI_W = 2 * (NPINS - MODE_SPLIT);

    logic [BUS_DW-1:0] spare_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            odata_q   <= '0;
            mode_lo_q <= '0;
            mode_hi_q <= '0;
            alt_q     <= '0;
            spare_q   <= '0;
        end else if (wr_fire) begin
            case (addr)
                W_WR_MASK:  mask_q    <= wdata[NPINS-1:0];
                W_OUT_DATA: odata_q   <= (odata_q & ~mask_q) | (wdata[NPINS-1:0] & mask_q);
                W_MODE_LO:  mode_lo_q <= wdata[LO_W-1:0];
                W_MODE_HI:  mode_hi_q <= wdata[HI_W-1:0];
                W_ALT_SEL:  alt_q     <= wdata[NPINS-1:0];
                W_SPARE:    spare_q   <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_word = '0;
        case (addr)
            W_PIN_LVL:  rd_word[NPINS-1:0] = pin_lvl;
            W_WR_MASK:  rd_word[NPINS-1:0] = mask_q;
            W_OUT_DATA: rd_word[NPINS-1:0] = odata_q;
            W_MODE_LO:  rd_word[LO_W-1:0]  = mode_lo_q;
            W_MODE_HI:  rd_word[HI_W-1:0]  = mode_hi_q;
            W_ALT_SEL:  rd_word[NPINS-1:0] = alt_q;
            W_SPARE:    rd_word            = spare_q;
            default:    rd_word            = '0;
        endcase
    end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_mux_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int MODE_SPLIT = 16
) (
    input  logic [NPINS-1:0]                odata_q,
    input  logic [2*MODE_SPLIT-1:0]         mode_lo_q,
    input  logic [2*(NPINS-MODE_SPLIT)-1:0] mode_hi_q,
    input  logic [NPINS-1:0]                alt_q,
    input  logic [NPINS-1:0]                alt_out,
    input  logic [NPINS-1:0]                alt_oe,
    output logic [NPINS-1:0]                pad_out,
    output logic [NPINS-1:0]                pad_oe
);
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [1:0] mode;
        if (p < MODE_SPLIT) begin : g_lo
            assign mode = mode_lo_q[2*p +: 2];
        end else begin : g_hi
            assign mode = mode_hi_q[2*(p-MODE_SPLIT) +: 2];
        end
        assign pad_oe[p]  = alt_q[p] ? alt_oe[p]  : (mode == PM_OUTPUT);
        assign pad_out[p] = alt_q[p] ? alt_out[p] : odata_q[p];
    end
endmodule

// File: rtl/gpio_mux_ctrl.sv
module gpio_mux_ctrl
    import gpio_mux_pkg::*;
#(
    parameter int NPINS      = 32,
    parameter int MODE_SPLIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [2:0]        bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic              bus_ready,
    output logic              bus_rvalid,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  alt_out,
    input  logic [NPINS-1:0]  alt_oe,
    output logic [NPINS-1:0]  alt_in
);
    logic                            wr_fire;
    logic [BUS_DW-1:0]               rd_word;
    logic [NPINS-1:0]                pin_lvl;
    logic [NPINS-1:0]                mask_q;
    logic [NPINS-1:0]                odata_q;
    logic [2*MODE_SPLIT-1:0]         mode_lo_q;
    logic [2*(NPINS-MODE_SPLIT)-1:0] mode_hi_q;
    logic [NPINS-1:0]                alt_q;

    gpio_in_sync #(.WIDTH(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_lvl)
    );

    gpio_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .rd_word(rd_word), .wr_fire(wr_fire), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata)
    );

    gpio_regfile #(.NPINS(NPINS), .MODE_SPLIT(MODE_SPLIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .addr(bus_addr),
        .wdata(bus_wdata), .pin_lvl(pin_lvl), .rd_word(rd_word),
        .mask_q(mask_q), .odata_q(odata_q), .mode_lo_q(mode_lo_q),
        .mode_hi_q(mode_hi_q), .alt_q(alt_q)
    );

    gpio_pad_mux #(.NPINS(NPINS), .MODE_SPLIT(MODE_SPLIT)) u_mux (
        .odata_q(odata_q), .mode_lo_q(mode_lo_q), .mode_hi_q(mode_hi_q),
        .alt_q(alt_q), .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    assign alt_in = pin_lvl;
endmodule

// File: rtl/gpio_mux_chk.sv
module gpio_mux_chk
    import gpio_mux_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic [2:0]       bus_addr,
    input logic             bus_ready,
    input logic             bus_rvalid,
    input logic [NPINS-1:0] pad_in,
    input logic [NPINS-1:0] alt_in,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] alt_oe,
    input logic [NPINS-1:0] alt_out,
    input logic [NPINS-1:0] odata_q,
    input logic [NPINS-1:0] mask_q,
    input logic [NPINS-1:0] alt_q
);
    logic [1:0] edges_q;
    logic       odata_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) edges_q <= '0;
        else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
    end

    assign odata_wr = bus_req && bus_we && bus_ready && (bus_addr == W_OUT_DATA);

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ready) |=> (bus_rvalid && !bus_ready)); // R2
    AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |=> (bus_ready && !bus_rvalid)); // R2
    AST_MASKED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        odata_wr |=> (((odata_q ^ $past(odata_q)) & ~$past(mask_q)) == '0)); // R4
    AST_ODATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !odata_wr |=> $stable(odata_q)); // R4
    AST_ALT_OE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_oe ^ alt_oe) | (pad_out ^ alt_out)) & alt_q) == '0); // R8
    AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q >= 2'd2) |-> (alt_in == $past(pad_in, 2))); // R10
endmodule

bind gpio_mux_ctrl gpio_mux_chk #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_ready(bus_ready), .bus_rvalid(bus_rvalid),
    .pad_in(pad_in), .alt_in(alt_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .alt_oe(alt_oe), .alt_out(alt_out), .odata_q(odata_q), .mask_q(mask_q),
    .alt_q(alt_q)
);

// File: tb/tb_gpio_mux_ctrl.sv
module tb_gpio_mux_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 32;
    localparam int SPLIT = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_req = 1'b0;
    logic          bus_we = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic          bus_ready, bus_rvalid;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
    logic [NP-1:0] alt_out = '0, alt_oe = '0, alt_in;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model of the register contents
    logic [31:0] m_mask, m_od, m_mlo, m_mhi, m_alt, m_spare;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_mux_ctrl #(.NPINS(NP), .MODE_SPLIT(SPLIT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_out(alt_out),
        .alt_oe(alt_oe), .alt_in(alt_in)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [1:0] f_mode(input int p);
        return (p < SPLIT) ? m_mlo[2*p +: 2] : m_mhi[2*(p-SPLIT) +: 2];
    endfunction

    function automatic logic [31:0] f_oe();
        logic [31:0] r;
        for (int p = 0; p < NP; p++)
            r[p] = m_alt[p] ? alt_oe[p] : (f_mode(p) == 2'b01);
        return r;
    endfunction

    function automatic logic [31:0] f_out();
        return (m_alt & alt_out) | (~m_alt & m_od);
    endfunction

    function automatic logic [31:0] f_read(input logic [2:0] a);
        case (a)
            3'd0: return pad_in;
            3'd1: return m_mask;
            3'd2: return m_od;
            3'd3: return m_mlo;
            3'd4: return m_mhi;
            3'd5: return m_alt;
            3'd6: return m_spare;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(input logic [2:0] a, input logic [31:0] d);
        case (a)
            3'd1: m_mask = d;
            3'd2: m_od = (m_od & ~m_mask) | (d & m_mask);
            3'd3: m_mlo = d;
            3'd4: m_mhi = d;
            3'd5: m_alt = d;
            3'd6: m_spare = d;
            default: ;
        endcase
    endtask

    // called at a falling edge, returns at a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic bus_read_chk(input logic [2:0] a, input string req);
        logic [31:0] exp;
        exp = f_read(a);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk); @(negedge clk);
        bus_req = 1'b0;
        chk("R2 rvalid", {31'h0, bus_rvalid}, 32'h1);
        chk("R2 ready low", {31'h0, bus_ready}, 32'h0);
        chk(req, bus_rdata, exp);
        @(posedge clk); @(negedge clk);
        chk("R2 ready back", {31'h0, bus_ready}, 32'h1);
    endtask

    task automatic set_pads(input logic [31:0] v);
        pad_in = v;
        repeat (3) @(negedge clk);
        chk("R10 alt_in", alt_in, v);
    endtask

    task automatic chk_pads(input string req);
        chk({req, " oe"}, pad_oe, f_oe());
        chk({req, " out"}, pad_out, f_out());
    endtask

    initial begin
        m_mask = '0; m_od = '0; m_mlo = '0; m_mhi = '0; m_alt = '0; m_spare = '0;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", pad_oe, 32'h0);
        chk("R1 ready", {31'h0, bus_ready}, 32'h1);
        chk("R1 rvalid", {31'h0, bus_rvalid}, 32'h0);
        for (int a = 1; a < 8; a++) bus_read_chk(3'(a), "R1 reg zero");

        // R4 masked output writes
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read_chk(3'd2, "R4 mask clear blocks write");
        bus_write(3'd1, 32'h0000_0100);
        bus_write(3'd2, 32'hFFFF_FFFF);
        bus_read_chk(3'd2, "R4 single bit");
        bus_write(3'd1, 32'h0F0F_0000);
        bus_write(3'd2, 32'hA5A5_A5A5);
        bus_read_chk(3'd2, "R4 partial mask");

        // R3 input word, write ignored
        set_pads(32'h1234_5678);
        bus_write(3'd0, 32'hFFFF_FFFF);
        bus_read_chk(3'd0, "R3 pin levels");

        // R9 unmapped word
        bus_write(3'd7, 32'hDEAD_BEEF);
        for (int a = 1; a < 8; a++) bus_read_chk(3'(a), "R9 no side effect");

        // R6/R7 mode boundary pins 15 and 16
        bus_write(3'd3, 32'h4000_0000);
        chk_pads("R6 pin15 output");
        chk("R6 pin15 oe", {31'h0, pad_oe[15]}, 32'h1);
        bus_write(3'd4, 32'h0000_0001);
        chk("R6 pin16 oe", {31'h0, pad_oe[16]}, 32'h1);
        bus_write(3'd4, 32'h0000_000E);
        chk("R7 codes 10/11 off", pad_oe, 32'h0000_8000);

        // R8 alternate select
        alt_oe = 32'h0001_8001; alt_out = 32'hFFFF_0000;
        bus_write(3'd5, 32'h0001_8003);
        chk_pads("R8 alt override");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom % 4);
            if (op == 0) begin
                logic [2:0] a;
                a = 3'($urandom % 8);
                bus_write(a, $urandom);
            end else if (op == 1) begin
                alt_oe = $urandom; alt_out = $urandom;
                set_pads($urandom);
            end else if (op == 2) begin
                bus_write(3'd1, $urandom & $urandom);
                bus_write(3'd2, $urandom);
            end else begin
                bus_read_chk(3'($urandom % 8), "R5 random readback");
            end
            chk_pads("R7 random pads");
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule